// File: doc/BRIEF.md
# Linked-Descriptor Peripheral DMA Engine

This block is a single-channel DMA engine that moves 32-bit words between system memory and one peripheral data port. Software writes one 64-bit control word. Its low five bits are command flags, and the bits above them carry the 32-byte-aligned address of the first descriptor. After a start command the engine reads each nine-word descriptor from memory and moves its data in the direction the descriptor selects. It pulses an interrupt when a descriptor that asks for one finishes, and it follows the descriptor's next pointer for as long as that pointer is marked valid.

Each descriptor describes a number of segments. Every segment holds the same number of words. Consecutive segments in memory are separated by a gap that is measured in words. If a chain's last next pointer leads back to an earlier descriptor, the chain becomes an endless ring, which suits continuous audio-style buffers. A stop command parks the engine on a word boundary. A later start command continues from exactly that point.

Top module: `chain_dma`

## Requirements
- R1: After reset `busy`, `irq`, `mem_req`, `per_rd` and `per_wr` are low, and `csr_rdata` reads zero.
- R2: A control write with bit 3 (start) set and bit 4 (stop) clear, made while the engine is idle, starts a fetch. The descriptor base is {bits 63:5, 5'b0}, and bits 63:32 count only if bit 0 is set. Nine words are read at base, base+4, … base+32. They are, in order: next-pointer low, memory address low, peripheral address, word count per segment, gap in words, segment count, command, next-pointer high, memory address high.
- R3: A descriptor moves count × segments words. Memory addresses rise by 4 within a segment, and each new segment begins gap × 4 bytes after the end of the previous one.
- R4: Command bit 12 selects the direction. When it is 1, words are read from memory and written with `per_wr`. When it is 0, words are read with `per_rd` and written to memory. Either way the peripheral address comes from the descriptor, and word order is preserved.
- R5: When a descriptor finishes and bit 0 of its next-pointer low word is 1, the next fetch starts at {next high, next low[31:1], 1'b0}. When that bit is 0, the engine returns to idle. A pointer back to an earlier descriptor forms a ring that keeps running.
- R6: If command bit 1 is set, `irq` is high for exactly one cycle after the descriptor's last word. A descriptor with a zero word count or a zero segment count moves nothing and still raises its interrupt.
- R7: While control bit 0 is clear, the high address words are treated as zero, so `mem_addr[63:32]` stays zero. While it is set, the memory address high word drives `mem_addr[63:32]`.
- R8: A write with bit 4 set, made while busy, halts the engine after the word in flight. `busy` then falls and no further request is issued. A later start write resumes the transfer with no word lost or repeated.
- R9: A start write made while busy is ignored. The transfer in progress continues, and `csr_rdata` keeps its value.
- R10: `mem_req` stays high with a stable address until `mem_ack`. `per_rd` and `per_wr` stay high until `per_ready`. The memory port and the peripheral port are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Control word write strobe |
| csr_wdata | input | 64 | Control word write data |
| csr_rdata | output | 64 | Last accepted control word |
| busy | output | 1 | Engine fetching or moving data |
| irq | output | 1 | Descriptor completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data |
| per_addr | output | 32 | Peripheral address from the descriptor |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data |
| per_ready | input | 1 | Peripheral completes the strobe |

## Verification
The bench builds the engine with its default 32-bit counters. Those counters cover every field value the bench writes, including a zero count, a zero segment count, a nonzero gap and segment counts above one. The memory and the peripheral answer after random delays, so a stop command can land in the fetch phase, the read phase or the write phase. The ring case and the 64-bit high-word case can both be reached without a large memory model, because the model folds addresses onto 4 KB.

// File: rtl/chain_dma.sv
`timescale 1ns/1ps
module chain_dma #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  output logic        busy,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [31:0] per_addr,
  output logic        per_rd,
  output logic        per_wr,
  output logic [31:0] per_wdata,
  input  logic [31:0] per_rdata,
  input  logic        per_ready
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_HALT} st_t;
  localparam logic [CNT_W-1:0] ONE = 1;

  st_t st, nst, resume_st;
  logic [63:0] ctrl, dptr, mptr;
  logic [3:0]  fidx;
  logic [31:0] d_next_lo, d_next_hi, d_mem_lo, d_per, buf_q;
  logic [CNT_W-1:0] d_len, d_gap, d_cnt, wcnt, scnt;
  logic d_irq, to_per, stop_pend, fin, adv;

  wire wide      = ctrl[0];
  wire cmd_stop  = csr_we && csr_wdata[4];
  wire cmd_start = csr_we && csr_wdata[3] && !csr_wdata[4];
  wire rd_done   = to_per ? mem_ack : per_ready;
  wire wr_done   = to_per ? per_ready : mem_ack;
  wire last_w    = (wcnt == d_len - ONE);
  wire last_s    = (scnt == d_cnt - ONE);
  wire empty     = (d_len == '0) || (d_cnt == '0);

  assign busy      = (st == S_FETCH) || (st == S_RD) || (st == S_WR);
  assign csr_rdata = ctrl;
  assign mem_req   = (st == S_FETCH) || (st == S_RD && to_per) || (st == S_WR && !to_per);
  assign mem_we    = (st == S_WR) && !to_per;
  assign mem_addr  = (st == S_FETCH) ? dptr + {58'd0, fidx, 2'b00} : mptr;
  assign mem_wdata = buf_q;
  assign per_rd    = (st == S_RD) && !to_per;
  assign per_wr    = (st == S_WR) && to_per;
  assign per_wdata = buf_q;
  assign per_addr  = d_per;

  always_comb begin
    nst = st;
    fin = 1'b0;
    adv = 1'b0;
    case (st)
      S_FETCH: if (mem_ack) begin
        adv = 1'b1;
        if (fidx == 4'd8) begin
          if (empty) fin = 1'b1;
          else nst = S_RD;
        end
      end
      S_RD: if (rd_done) begin
        adv = 1'b1;
        nst = S_WR;
      end
      S_WR: if (wr_done) begin
        adv = 1'b1;
        if (last_w && last_s) fin = 1'b1;
        else nst = S_RD;
      end
      default: ;
    endcase
    if (fin) nst = d_next_lo[0] ? S_FETCH : S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  resume_st <= S_IDLE;
      ctrl <= '0;    dptr <= '0;  mptr <= '0;  fidx <= '0;
      d_next_lo <= '0; d_next_hi <= '0; d_mem_lo <= '0; d_per <= '0;
      d_len <= '0;   d_gap <= '0; d_cnt <= '0; wcnt <= '0; scnt <= '0;
      d_irq <= 1'b0; to_per <= 1'b0; buf_q <= '0;
      stop_pend <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= fin && d_irq;
      if (adv) begin
        if (stop_pend && nst != S_IDLE) begin
          st <= S_HALT;
          resume_st <= nst;
          stop_pend <= 1'b0;
        end else begin
          st <= nst;
          if (nst == S_IDLE) stop_pend <= 1'b0;
        end
      end
      if (st == S_FETCH && mem_ack) begin
        fidx <= fidx + 4'd1;
        case (fidx)
          4'd0: d_next_lo <= mem_rdata;
          4'd1: d_mem_lo  <= mem_rdata;
          4'd2: d_per     <= mem_rdata;
          4'd3: d_len     <= mem_rdata[CNT_W-1:0];
          4'd4: d_gap     <= mem_rdata[CNT_W-1:0];
          4'd5: d_cnt     <= mem_rdata[CNT_W-1:0];
          4'd6: begin d_irq <= mem_rdata[1]; to_per <= mem_rdata[12]; end
          4'd7: d_next_hi <= mem_rdata;
          default: begin
            mptr <= {wide ? mem_rdata : 32'd0, d_mem_lo};
            wcnt <= '0;
            scnt <= '0;
          end
        endcase
      end
      if (st == S_RD && rd_done) buf_q <= to_per ? mem_rdata : per_rdata;
      if (st == S_WR && wr_done) begin
        if (!last_w) begin
          wcnt <= wcnt + ONE;
          mptr <= mptr + 64'd4;
        end else begin
          wcnt <= '0;
          scnt <= scnt + ONE;
          mptr <= mptr + 64'd4 + ({{(64-CNT_W){1'b0}}, d_gap} << 2);
        end
      end
      if (fin) begin
        dptr <= {wide ? d_next_hi : 32'd0, d_next_lo[31:1], 1'b0};
        fidx <= '0;
      end
      if (cmd_stop) begin
        ctrl <= csr_wdata;
        if (busy && !stop_pend && !(adv && nst == S_IDLE)) stop_pend <= 1'b1;
      end else if (cmd_start) begin
        if (st == S_IDLE) begin
          ctrl <= csr_wdata;
          dptr <= {csr_wdata[0] ? csr_wdata[63:32] : 32'd0, csr_wdata[31:5], 5'b0};
          fidx <= '0;
          stop_pend <= 1'b0;
          st <= S_FETCH;
        end else if (st == S_HALT) begin
          ctrl <= csr_wdata;
          st <= resume_st;
        end
      end else if (csr_we) begin
        ctrl <= csr_wdata;
      end
    end
  end
endmodule

// File: rtl/chain_dma_chk.sv
`timescale 1ns/1ps
module chain_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        irq,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        mem_ack,
  input logic        per_rd,
  input logic        per_wr,
  input logic        per_ready
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10
  AST_PER_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr && !per_ready |=> per_wr); // R10
  AST_PER_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    per_rd && !per_ready |=> per_rd); // R10
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && (per_rd || per_wr))); // R10
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R3
  AST_QUIET_WHEN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !per_rd && !per_wr); // R8
endmodule

bind chain_dma chain_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .per_rd(per_rd), .per_wr(per_wr),
  .per_ready(per_ready)
);

// File: tb/chain_dma_bench.sv
`timescale 1ns/1ps
module chain_dma_bench;
  logic clk, rst_n, csr_we, busy, irq;
  logic [63:0] csr_wdata, csr_rdata, mem_addr;
  logic mem_req, mem_we, mem_ack, per_rd, per_wr, per_ready;
  logic [31:0] mem_wdata, mem_rdata, per_addr, per_wdata, per_rdata;

  chain_dma u_chain_dma (.*);

  logic [31:0] mem [0:1023];
  logic [31:0] plog [0:1023];
  logic [31:0] palog [0:1023];
  logic [31:0] alog [0:63];
  int pn, an, rdn, irqn, nchk, nfail;
  logic [31:0] src_val, hi_seen;

  initial begin clk = 0; forever #2.5 clk = ~clk; end

  initial begin
    mem_ack = 0; mem_rdata = 0; an = 0; hi_seen = 0;
    forever begin
      @(negedge clk);
      if (mem_req && mem_addr[63:32] != 0) hi_seen = mem_addr[63:32];
      if (mem_req && ($urandom % 4) != 0) begin
        mem_ack = 1;
        mem_rdata = mem[mem_addr[11:2]];
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        if (an < 64) alog[an] = mem_addr[31:0];
        an++;
      end else mem_ack = 0;
    end
  end

  initial begin
    per_ready = 0; per_rdata = 0; pn = 0; rdn = 0; src_val = 32'hA000_0000;
    forever begin
      @(negedge clk);
      if ((per_rd || per_wr) && ($urandom % 3) != 0) begin
        per_ready = 1;
        if (per_wr && pn < 1024) begin plog[pn] = per_wdata; palog[pn] = per_addr; end
        if (per_wr) pn++;
        if (per_rd) begin per_rdata = src_val; src_val++; rdn++; end
      end else per_ready = 0;
    end
  end

  initial begin irqn = 0; forever begin @(negedge clk); if (irq) irqn++; end end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int word_at(int base_w, int len, int gap, int s, int w);
    return base_w + s * (len + gap) + w;
  endfunction

  task automatic put_desc(input int w, input logic [31:0] nlo, mlo, pa, len, gap, cnt, cmd, nhi, mhi);
    mem[w] = nlo; mem[w+1] = mlo; mem[w+2] = pa; mem[w+3] = len; mem[w+4] = gap;
    mem[w+5] = cnt; mem[w+6] = cmd; mem[w+7] = nhi; mem[w+8] = mhi;
  endtask

  task automatic csr_write(input logic [63:0] v);
    @(negedge clk); csr_we = 1; csr_wdata = v;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, req, t, 0);
  endtask

  int p0, i0, r0;
  logic [31:0] exp_v;
  localparam logic [31:0] M2P = 32'h1000, IRQB = 32'h2;

  initial begin
    void'($urandom(32'd2024));
    nchk = 0; nfail = 0; csr_we = 0; csr_wdata = 0; rst_n = 0;
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !mem_req && !per_rd && !per_wr, "R1 idle outputs", {busy, irq, mem_req}, 0);
    chk(csr_rdata == 0, "R1 control reads zero", csr_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    // T1: single m2p descriptor, 3 words x 2 segments, gap 1
    put_desc(0, 0, 256 * 4, 32'h40, 3, 1, 2, M2P | IRQB, 0, 0);
    an = 0; p0 = pn; i0 = irqn;
    csr_write(64'h9);
    chk(busy, "R2 busy after start", busy, 1);
    wait_idle("R5 chain end returns idle");
    for (int i = 0; i < 9; i++) chk(alog[i] == i * 4, "R2 fetch order", alog[i], i * 4);
    chk(pn - p0 == 6, "R3 word total", pn - p0, 6);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 3; w++) begin
        exp_v = mem[word_at(256, 3, 1, s, w)];
        chk(plog[p0 + s * 3 + w] == exp_v, "R4 m2p data", plog[p0 + s * 3 + w], exp_v);
        chk(palog[p0 + s * 3 + w] == 32'h40, "R4 peripheral address", palog[p0 + s * 3 + w], 32'h40);
      end
    chk(irqn - i0 == 1, "R6 one interrupt", irqn - i0, 1);
    chk(csr_rdata == 64'h9, "R2 control readback", csr_rdata, 64'h9);

    // T2: p2m chain of two, only second flagged
    put_desc(16, 32 * 4 + 1, 512 * 4, 32'h80, 4, 0, 1, 0, 0, 0);
    put_desc(32, 0, 520 * 4, 32'h80, 2, 2, 2, IRQB, 0, 0);
    r0 = rdn; i0 = irqn; exp_v = src_val;
    csr_write(64'd16 * 4 | 64'h9);
    wait_idle("R5 two-link chain");
    chk(rdn - r0 == 8, "R4 p2m read count", rdn - r0, 8);
    for (int w = 0; w < 4; w++) chk(mem[512 + w] == exp_v + w, "R5 first link data", mem[512 + w], exp_v + w);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++)
        chk(mem[word_at(520, 2, 2, s, w)] == exp_v + 4 + s * 2 + w, "R3 gap layout",
            mem[word_at(520, 2, 2, s, w)], exp_v + 4 + s * 2 + w);
    chk(irqn - i0 == 1, "R6 only flagged link interrupts", irqn - i0, 1);

    // T3: random single descriptors
    for (int k = 0; k < 8; k++) begin
      int len, gap, cnt; bit dir, fl;
      len = 1 + $urandom % 5; gap = $urandom % 4; cnt = 1 + $urandom % 3;
      dir = $urandom % 2; fl = $urandom % 2;
      put_desc(48, 0, 600 * 4, 32'h100 + k, len, gap, cnt, (dir ? M2P : 0) | (fl ? IRQB : 0), 0, 0);
      p0 = pn; r0 = rdn; i0 = irqn; exp_v = src_val;
      csr_write(64'd48 * 4 | 64'h9);
      wait_idle("R3 random run");
      chk(irqn - i0 == int'(fl), "R6 random flag", irqn - i0, fl);
      if (dir) begin
        chk(pn - p0 == len * cnt, "R3 random m2p count", pn - p0, len * cnt);
        for (int s = 0; s < cnt; s++)
          for (int w = 0; w < len; w++)
            chk(plog[p0 + s * len + w] == mem[word_at(600, len, gap, s, w)], "R4 random m2p data",
                plog[p0 + s * len + w], mem[word_at(600, len, gap, s, w)]);
      end else begin
        chk(rdn - r0 == len * cnt, "R3 random p2m count", rdn - r0, len * cnt);
        for (int s = 0; s < cnt; s++)
          for (int w = 0; w < len; w++)
            chk(mem[word_at(600, len, gap, s, w)] == exp_v + s * len + w, "R4 random p2m data",
                mem[word_at(600, len, gap, s, w)], exp_v + s * len + w);
      end
    end

    // T4: zero-length descriptor then a one-word descriptor
    put_desc(64, 80 * 4 + 1, 700 * 4, 32'h44, 0, 0, 3, M2P | IRQB, 0, 0);
    put_desc(80, 0, 701 * 4, 32'h44, 1, 0, 1, M2P | IRQB, 0, 0);
    p0 = pn; i0 = irqn;
    csr_write(64'd64 * 4 | 64'h9);
    wait_idle("R6 empty link");
    chk(irqn - i0 == 2, "R6 empty descriptor interrupts", irqn - i0, 2);
    chk(pn - p0 == 1, "R6 empty descriptor moves nothing", pn - p0, 1);
    chk(plog[p0] == mem[701], "R6 following link data", plog[p0], mem[701]);

    // T5: pause and resume
    put_desc(96, 0, 800 * 4, 32'h48, 8, 0, 4, M2P, 0, 0);
    p0 = pn;
    csr_write(64'd96 * 4 | 64'h9);
    repeat (40) @(negedge clk);
    csr_write(64'd96 * 4 | 64'h11);
    wait_idle("R8 stop settles");
    r0 = pn;
    repeat (40) @(negedge clk);
    chk(pn == r0, "R8 halted moves nothing", pn, r0);
    chk(!busy && !mem_req, "R8 halted quiet", {busy, mem_req}, 0);
    chk(pn - p0 < 32, "R8 halted mid-transfer", pn - p0, 32);
    csr_write(64'd96 * 4 | 64'h9);
    wait_idle("R8 resume completes");
    chk(pn - p0 == 32, "R8 no word lost or repeated", pn - p0, 32);
    for (int w = 0; w < 32; w++) chk(plog[p0 + w] == mem[800 + w], "R8 resumed order", plog[p0 + w], mem[800 + w]);

    // T6: start while busy ignored
    put_desc(112, 0, 850 * 4, 32'h4C, 8, 0, 2, M2P, 0, 0);
    put_desc(128, 0, 900 * 4, 32'h4C, 4, 0, 1, 0, 0, 0);
    p0 = pn; r0 = rdn;
    csr_write(64'd112 * 4 | 64'h9);
    repeat (5) @(negedge clk);
    csr_write(64'd128 * 4 | 64'h9);
    chk(csr_rdata == (64'd112 * 4 | 64'h9), "R9 control kept", csr_rdata, 64'd112 * 4 | 64'h9);
    wait_idle("R9 first transfer completes");
    chk(pn - p0 == 16 && rdn == r0, "R9 second start ignored", pn - p0, 16);

    // T7: high address words
    put_desc(144, 0, 950 * 4, 32'h50, 2, 0, 1, M2P, 32'h55, 32'h77);
    hi_seen = 0;
    csr_write(64'd144 * 4 | 64'h8);
    wait_idle("R7 narrow run");
    chk(hi_seen == 0, "R7 narrow mode keeps high zero", hi_seen, 0);
    hi_seen = 0;
    csr_write(64'd144 * 4 | 64'h9);
    wait_idle("R7 wide run");
    chk(hi_seen == 32'h77, "R7 wide mode uses high word", hi_seen, 32'h77);

    // T8: ring of two
    put_desc(160, 176 * 4 + 1, 960 * 4, 32'h54, 2, 0, 1, M2P | IRQB, 0, 0);
    put_desc(176, 160 * 4 + 1, 970 * 4, 32'h54, 2, 0, 1, M2P | IRQB, 0, 0);
    p0 = pn; i0 = irqn;
    csr_write(64'd160 * 4 | 64'h9);
    begin
      int t = 0;
      while (irqn - i0 < 5 && t < 20000) begin @(negedge clk); t++; end
      chk(t < 20000, "R5 ring keeps running", irqn - i0, 5);
    end
    csr_write(64'd160 * 4 | 64'h11);
    wait_idle("R5 ring stops");
    chk(pn - p0 >= 10, "R5 ring word count", pn - p0, 10);
    for (int w = 0; w < 10; w++) begin
      exp_v = mem[((w / 2) % 2 == 0 ? 960 : 970) + w % 2];
      chk(plog[p0 + w] == exp_v, "R5 ring order", plog[p0 + w], exp_v);
    end
    summary();
  end
endmodule